// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block holds the interrupt state of a single DMA channel and is reached over a simple 32-bit register bus. The channel's data mover and descriptor fetch logic are not part of it. They only send one-cycle event pulses: descriptor done on either side, transfer done, pause, four bus error kinds and byte count overflow. Each pulse latches a bit in a 12-bit status register. Software clears status bits by writing ones to them.

A 12-bit mask register starts with every source masked. Software can change it only through two strobe registers: one unmasks the bits it is given and the other masks them. A single level interrupt output is high while any status bit is set and its mask bit is clear. Two 8-bit accounting counters count descriptor completions on the source side and on the destination side. Reading a counter clears it. A counter that wraps raises its own error status bit. Any access to an address that maps to no register is flagged in status.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Each event input sets its own status bit at the clock edge that ends the pulse cycle: pause bit 11, transfer done bit 10, `evtBusErr[3:0]` bits 9 down to 6 (write data, read data, destination descriptor read, source descriptor read), byte count overflow bit 3, destination descriptor done bit 2, source descriptor done bit 1. Status is read at byte offset 0x00.
- R2: Writing to offset 0x00 clears every status bit whose write data bit is one and leaves the other bits unchanged. Status read data bits 31:12 are always zero.
- R3: The mask register, read at offset 0x04, resets to 0xFFF. A write to offset 0x04 leaves it unchanged and does not count as an invalid access.
- R4: A write to offset 0x08 clears the mask bits given by ones in the write data. A write to offset 0x0C sets them. Both offsets read as zero.
- R5: `irqOut` is high exactly when some status bit is one while the matching mask bit is zero. It follows the registers with no added cycle.
- R6: Each source descriptor done pulse increments the source counter (offset 0x10). Each destination descriptor done pulse increments the destination counter (offset 0x14). Both counters reset to zero.
- R7: When the source counter wraps from 255 to 0, status bit 4 is set. When the destination counter wraps, status bit 5 is set.
- R8: A read of a counter returns its current value, and the counter is zero after that access cycle.
- R9: Offsets are decoded on address bits 7:2. Any offset other than 0x00 to 0x14 is unmapped. An access to an unmapped offset, read or write, sets status bit 0. Such a read returns zero and such a write changes nothing else.
- R10: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R11: When a counter is read in the same cycle as an increment, the read returns the old value and the counter ends at 1.
- R12: Read data is valid combinationally during the access cycle, and write side effects take effect at the clock edge that ends it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access in this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the current access |
| evtPause | input | 1 | Channel paused pulse |
| evtDmaDone | input | 1 | Transfer done pulse |
| evtBusErr | input | 4 | Bus error pulses, one per kind |
| evtByteOvf | input | 1 | Byte count overflow pulse |
| evtSrcDone | input | 1 | Source descriptor done (interrupt flagged) pulse |
| evtDstDone | input | 1 | Destination descriptor done (interrupt flagged) pulse |
| irqOut | output | 1 | Level interrupt request |

## Verification
The status path is driven with single events and with grouped error events. This checks that each pulse lands on its own bit and on no other. Clearing writes carry mixed patterns with high reserved bits set, which tells a partial clear apart from a full one. Mask strobe patterns are written both to the strobe offsets and directly to the mask offset, so the two routes can be distinguished. The counters are run to exactly 255 and then one step further, which separates an early wrap flag from a correct one. Same-cycle collisions (an event against a clear, an increment against a read) check the ordering rules that a plain sequential model would hide.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int STAT_W = 12;

  // status bit positions
  localparam int B_BAD      = 0;
  localparam int B_SRC_DONE = 1;
  localparam int B_DST_DONE = 2;
  localparam int B_BYTE_OVF = 3;
  localparam int B_SRC_ERR  = 4;
  localparam int B_DST_ERR  = 5;
  localparam int B_BUS_LO   = 6;
  localparam int B_DMA_DONE = 10;
  localparam int B_PAUSE    = 11;

  // word offsets on the register bus
  localparam int W_STATUS = 0;
  localparam int W_MASK   = 1;
  localparam int W_UNMASK = 2;
  localparam int W_DOMASK = 3;
  localparam int W_SRCCNT = 4;
  localparam int W_DSTCNT = 5;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STATUS,
    RD_MASK,
    RD_SRCCNT,
    RD_DSTCNT
  } rdSel_t;

  typedef struct packed {
    logic   statusClr;
    logic   maskEn;
    logic   maskDis;
    logic   srcCntRd;
    logic   dstCntRd;
    logic   badAccess;
    rdSel_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/irq_acct_counter.sv
module irq_acct_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             clrRd,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  assign wrap = inc && !clrRd && (count == '1);

  always_ff @(posedge clk) begin
    if (!rstN)      count <= '0;
    else if (clrRd) count <= CNT_W'(inc);
    else if (inc)   count <= count + 1'b1;
  end

  AST_RDINC_ENDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (clrRd && inc) |=> (count == CNT_W'(1)));  // R11
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (count == '0));  // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrRd && !inc) |=> (count == '0));  // R8

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              unusedAddrBits;

  assign wordIdx        = regAddr[ADDR_W-1:2];
  assign unusedAddrBits = ^regAddr[1:0];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    if (regSel) begin
      case (wordIdx)
        WORD_W'(W_STATUS): begin
          strb.statusClr = regWrite;
          if (!regWrite) strb.rdSel = RD_STATUS;
        end
        WORD_W'(W_MASK): begin
          if (!regWrite) strb.rdSel = RD_MASK;
        end
        WORD_W'(W_UNMASK): strb.maskEn  = regWrite;
        WORD_W'(W_DOMASK): strb.maskDis = regWrite;
        WORD_W'(W_SRCCNT): begin
          strb.srcCntRd = !regWrite;
          if (!regWrite) strb.rdSel = RD_SRCCNT;
        end
        WORD_W'(W_DSTCNT): begin
          strb.dstCntRd = !regWrite;
          if (!regWrite) strb.rdSel = RD_DSTCNT;
        end
        default: strb.badAccess = 1'b1;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.statusClr, strb.maskEn, strb.maskDis,
              strb.srcCntRd, strb.dstCntRd, strb.badAccess}));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> (strb.rdSel == RD_ZERO && !strb.badAccess));  // R12

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import dma_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strb,
  input  logic [31:0] regWdata,
  input  logic        evtPause,
  input  logic        evtDmaDone,
  input  logic [3:0]  evtBusErr,
  input  logic        evtByteOvf,
  input  logic        evtSrcDone,
  input  logic        evtDstDone,
  output logic [31:0] regRdata,
  output logic        irqOut
);

  logic [STAT_W-1:0] statusQ, maskQ, setVec, clrVec, enVec, disVec;
  logic [1:0]        acctInc, acctClr, acctWrap;
  logic [CNT_W-1:0]  acctCnt [2];
  logic              unusedWdataHi;

  assign unusedWdataHi = ^regWdata[31:STAT_W];
  assign acctInc = {evtDstDone, evtSrcDone};
  assign acctClr = {strb.dstCntRd, strb.srcCntRd};

  for (genvar g = 0; g < 2; g++) begin : gAcct
    irq_acct_counter #(.CNT_W(CNT_W)) uCnt (
      .clk   (clk),
      .rstN  (rstN),
      .inc   (acctInc[g]),
      .clrRd (acctClr[g]),
      .count (acctCnt[g]),
      .wrap  (acctWrap[g])
    );
  end

  always_comb begin
    setVec                     = '0;
    setVec[B_PAUSE]            = evtPause;
    setVec[B_DMA_DONE]         = evtDmaDone;
    setVec[B_BUS_LO+3:B_BUS_LO] = evtBusErr;
    setVec[B_DST_ERR]          = acctWrap[1];
    setVec[B_SRC_ERR]          = acctWrap[0];
    setVec[B_BYTE_OVF]         = evtByteOvf;
    setVec[B_DST_DONE]         = evtDstDone;
    setVec[B_SRC_DONE]         = evtSrcDone;
    setVec[B_BAD]              = strb.badAccess;
  end

  assign clrVec = strb.statusClr ? regWdata[STAT_W-1:0] : '0;
  assign enVec  = strb.maskEn    ? regWdata[STAT_W-1:0] : '0;
  assign disVec = strb.maskDis   ? regWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
      maskQ   <= (maskQ & ~enVec) | disVec;
    end
  end

  assign irqOut = |(statusQ & ~maskQ);

  always_comb begin
    case (strb.rdSel)
      RD_STATUS: regRdata = 32'(statusQ);
      RD_MASK:   regRdata = 32'(maskQ);
      RD_SRCCNT: regRdata = 32'(acctCnt[0]);
      RD_DSTCNT: regRdata = 32'(acctCnt[1]);
      default:   regRdata = '0;
    endcase
  end

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ((~statusQ & $past(statusQ) & ~$past(clrVec)) == '0));  // R2
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.maskEn || strb.maskDis) |-> $stable(maskQ));  // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    evtPause |=> statusQ[B_PAUSE]);  // R10
  AST_SRC_DONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    evtSrcDone |=> statusQ[B_SRC_DONE]);  // R6
  AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    strb.badAccess |=> statusQ[B_BAD]);  // R9
  AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    acctWrap[1] |=> statusQ[B_DST_ERR]);  // R7

endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              evtPause,
  input  logic              evtDmaDone,
  input  logic [3:0]        evtBusErr,
  input  logic              evtByteOvf,
  input  logic              evtSrcDone,
  input  logic              evtDstDone,
  output logic              irqOut
);

  regStrobe_t strb;

  irq_reg_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  irq_reg_bank #(.CNT_W(CNT_W)) uBank (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWdata   (regWdata),
    .evtPause   (evtPause),
    .evtDmaDone (evtDmaDone),
    .evtBusErr  (evtBusErr),
    .evtByteOvf (evtByteOvf),
    .evtSrcDone (evtSrcDone),
    .evtDstDone (evtDstDone),
    .regRdata   (regRdata),
    .irqOut     (irqOut)
  );

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (uBank.statusQ != '0));  // R5

endmodule

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0, regWrite = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        evtPause = 0, evtDmaDone = 0, evtByteOvf = 0, evtSrcDone = 0, evtDstDone = 0;
  logic [3:0]  evtBusErr = '0;
  logic        irqOut;

  always #4 clk = ~clk;  // 125 MHz

  dma_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .evtPause(evtPause), .evtDmaDone(evtDmaDone), .evtBusErr(evtBusErr),
    .evtByteOvf(evtByteOvf), .evtSrcDone(evtSrcDone), .evtDstDone(evtDstDone),
    .irqOut(irqOut)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  // bench model of the register state
  logic [11:0] mStatus = '0;
  logic [11:0] mMask   = 12'hFFF;
  int          mSrc = 0, mDst = 0;

  // monitor: compares read data in the middle of the access cycle
  always @(negedge clk) begin
    if (rstN && regSel && !regWrite) begin
      logic [31:0] e;
      string t;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected read act=%h exp=none", regRdata);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (regRdata !== e) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", t, regRdata, e);
        end
      end
    end
  end

  task automatic checkIrq(input string tag);
    logic e;
    e = |(mStatus & ~mMask);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL R5 irq after %s act=%0b exp=%0b", tag, irqOut, e);
    end
  endtask

  // driver: one cycle of bus access and/or event pulses, model updated alongside
  task automatic step(input bit acc, input bit wr, input logic [7:0] addr,
                      input logic [31:0] data, input logic [11:0] ev, input string tag);
    int word;
    logic [31:0] expRd;
    logic [11:0] setV, clrV;
    bit srcClr, dstClr;
    @(posedge clk); #1;
    regSel = acc; regWrite = wr; regAddr = addr; regWdata = data;
    evtPause = ev[11]; evtDmaDone = ev[10]; evtBusErr = ev[9:6];
    evtByteOvf = ev[3]; evtDstDone = ev[2]; evtSrcDone = ev[1];
    word = int'(addr[7:2]);
    case (word)
      0: expRd = {20'b0, mStatus};
      1: expRd = {20'b0, mMask};
      4: expRd = 32'(mSrc);
      5: expRd = 32'(mDst);
      default: expRd = '0;
    endcase
    if (acc && !wr) begin
      expQ.push_back(expRd);
      tagQ.push_back(tag);
    end
    setV = ev & 12'hFCE;
    clrV = '0;
    srcClr = acc && !wr && word == 4;
    dstClr = acc && !wr && word == 5;
    if (ev[1] && !srcClr && mSrc == 255) setV[4] = 1'b1;
    if (ev[2] && !dstClr && mDst == 255) setV[5] = 1'b1;
    mSrc = srcClr ? int'(ev[1]) : (mSrc + int'(ev[1])) % 256;
    mDst = dstClr ? int'(ev[2]) : (mDst + int'(ev[2])) % 256;
    if (acc && word > 5) setV[0] = 1'b1;
    if (acc && wr && word == 0) clrV = data[11:0];
    if (acc && wr && word == 2) mMask = mMask & ~data[11:0];
    if (acc && wr && word == 3) mMask = mMask | data[11:0];
    mStatus = (mStatus & ~clrV) | setV;
    @(posedge clk); #1;
    regSel = 0; regWrite = 0;
    evtPause = 0; evtDmaDone = 0; evtBusErr = '0; evtByteOvf = 0; evtDstDone = 0; evtSrcDone = 0;
    checkIrq(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 12'h000, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 32'h0, 12'h000, tag);
  endtask
  task automatic pulse(input logic [11:0] ev, input string tag);
    step(0, 0, 8'h00, 32'h0, ev, tag);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    checkIrq("R5 reset");
    rd(8'h00, "R1 status after reset");
    rd(8'h04, "R3 mask after reset");
    rd(8'h10, "R6 source count after reset");
    rd(8'h14, "R6 destination count after reset");

    pulse(12'h400, "R1 transfer done event");
    rd(8'h00, "R1 transfer done bit 10 masked");
    wr(8'h08, 32'h400, "R4 unmask bit 10");
    rd(8'h04, "R4 unmask clears mask bit");
    rd(8'h08, "R4 unmask offset reads zero");
    wr(8'h0C, 32'h400, "R4 mask bit 10");
    rd(8'h04, "R4 mask sets bit again");
    rd(8'h0C, "R4 mask offset reads zero");
    wr(8'h00, 32'hFFFF_F400, "R2 clear bit 10");
    rd(8'h00, "R2 cleared and reserved zero");

    wr(8'h04, 32'h0, "R3 direct mask write");
    rd(8'h04, "R3 mask unchanged");
    rd(8'h00, "R3 direct write not invalid");
    wr(8'h08, 32'hFFF, "R4 unmask all");

    pulse(12'h3C8, "R1 bus errors and overflow");
    rd(8'h00, "R1 error bits 9 to 6 and 3");
    wr(8'h00, 32'h0000_0208, "R2 partial clear");
    rd(8'h00, "R2 partial clear leaves others");
    wr(8'h00, 32'hFFF, "R2 clear all");

    wr(8'h40, 32'h123, "R9 unmapped write");
    rd(8'h00, "R9 invalid flag after write");
    rd(8'h04, "R9 unmapped write changed no mask");
    wr(8'h00, 32'h1, "R2 clear invalid flag");
    rd(8'h3C, "R9 unmapped read returns zero");
    rd(8'h00, "R9 invalid flag after read");
    wr(8'h00, 32'h1, "R2 clear invalid flag");

    for (int i = 0; i < 3; i++) pulse(12'h002, "R6 source done");
    rd(8'h00, "R6 source done bit");
    rd(8'h10, "R6 source count three");
    rd(8'h10, "R8 source count cleared");
    wr(8'h00, 32'h2, "R2 clear source done");

    for (int i = 0; i < 255; i++) pulse(12'h004, "R6 destination done");
    rd(8'h00, "R7 no error before wrap");
    pulse(12'h004, "R7 destination wrap");
    rd(8'h00, "R7 destination wrap sets bit 5");
    rd(8'h14, "R7 destination count wrapped");
    wr(8'h00, 32'hFFF, "R2 clear all");

    for (int i = 0; i < 256; i++) pulse(12'h002, "R6 source done");
    rd(8'h00, "R7 source wrap sets bit 4");
    wr(8'h00, 32'hFFF, "R2 clear all");

    pulse(12'h800, "R1 pause event");
    step(1, 1, 8'h00, 32'h800, 12'h800, "R10 event with clear");
    rd(8'h00, "R10 pause bit still set");
    wr(8'h00, 32'hFFF, "R2 clear all");

    pulse(12'h002, "R6 source done");
    pulse(12'h002, "R6 source done");
    step(1, 0, 8'h10, 32'h0, 12'h002, "R11 read during increment");
    rd(8'h10, "R11 count ends at one");
    wr(8'h0C, 32'hFFF, "R4 mask all");
    rd(8'h00, "R5 status pending while masked");

    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule